// File: doc/BRIEF.md
# Card Socket Power Sequencer

This block brings power to a removable card slot in a fixed order and takes it away again. It drives a 2-bit Vcc select, a 2-bit Vpp select and an active-high card reset. A one-cycle enable request starts the power-up run. The run first forces both supplies to their 0 V codes and waits long enough for the slot to discharge. It then selects 5 V Vcc with Vpp left off and waits for the supply to rise and settle, with extra margin. Next it pulses the card reset, waits a short time after the reset is released, and reports the slot ready.

A disable request, or a falling edge on the card-detect input, aborts the run from any state except idle and power-down. Either one removes power and waits for the supply to fall before the block returns to idle. The card-detect input is synchronised inside the block before its falling edge is taken. Every wait is a cycle count derived from a clock-frequency parameter and a divider parameter, so a bench can shrink the times by a known factor.

States and transitions: IDLE goes to OFF_WAIT on enable. OFF_WAIT goes to VCC_WAIT when its timer expires. VCC_WAIT goes to RESET_HOLD on expiry. RESET_HOLD goes to POST_RESET on expiry. POST_RESET goes to READY on expiry. DOWN_WAIT goes to IDLE on expiry. Every state from OFF_WAIT through READY goes to DOWN_WAIT on disable or card removal.

Top module: `socket_pwr_seq`

## Requirements
- R1: While reset is asserted and after it, vcc_sel and vpp_sel are 2'b00 (the 0 V code), card_rst is 0, and busy and ready are 0.
- R2: An enable request in IDLE enters OFF_WAIT on the next cycle. OFF_WAIT holds Vcc at 2'b00, keeps busy at 1 and lasts OFF cycles (20 ms + 300 ms + 100 ms scaled).
- R3: VCC_WAIT drives vcc_sel to 2'b01 (the 5 V code) with vpp_sel at 2'b00 and card_rst at 0. It lasts VCC cycles (100 ms + 20 ms + 300 ms scaled).
- R4: card_rst is 1 only in RESET_HOLD, which directly follows VCC_WAIT with Vcc at 2'b01. It lasts RST cycles (10 us scaled, at least 1).
- R5: POST_RESET lasts POST cycles (20 ms scaled) with card_rst at 0. The block then enters READY, where ready is 1, busy is 0 and vcc_sel stays 2'b01.
- R6: A disable request in OFF_WAIT, VCC_WAIT, RESET_HOLD, POST_RESET or READY enters DOWN_WAIT on the next cycle. DOWN_WAIT holds Vcc at 2'b00, card_rst at 0 and busy at 1, and lasts DOWN cycles (20 ms + 300 ms scaled). The block then returns to IDLE.
- R7: A falling edge on card_det has the same effect as a disable request after SYNC_STAGES synchroniser cycles. With the default of 2, power drops on the third clock edge after the input falls.
- R8: An enable request is ignored in every state other than IDLE. An enable in READY leaves READY, and an enable during OFF_WAIT does not restart its timer.
- R9: A disable request or card removal in IDLE leaves the block in IDLE. A disable takes priority over an enable that arrives in the same cycle.
- R10: Each wait lasts max(1, CLK_HZ * t_us / 1e6 / TICK_DIV) cycles, counted from the first cycle spent in the state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_req | input | 1 | Power-up request, one cycle |
| dis_req | input | 1 | Power-down request, one cycle |
| card_det | input | 1 | Card present (1) / absent (0), asynchronous |
| vcc_sel | output | 2 | Vcc select: 2'b00 = 0 V, 2'b01 = 5 V |
| vpp_sel | output | 2 | Vpp select: 2'b00 = 0 V |
| card_rst | output | 1 | Active-high card reset |
| busy | output | 1 | High in every state except IDLE and READY |
| ready | output | 1 | Socket powered and released from reset |

## Verification
The bench builds the block with CLK_HZ = 1,000,000 and TICK_DIV = 200. This gives waits of 2100, 2100, 1, 100 and 1600 cycles. A full power-up then takes about 4300 cycles, so the exact first and last cycle of every phase can be checked several times within the run. The 10 us reset time scales below one cycle at these values, which exercises the one-cycle floor. The default SYNC_STAGES of 2 makes the three-edge latency of a card-removal abort checkable at a fixed sample.

// File: rtl/sps_pkg.sv
package sps_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_OFF_WAIT,
        ST_VCC_WAIT,
        ST_RESET_HOLD,
        ST_POST_RESET,
        ST_READY,
        ST_DOWN_WAIT
    } seq_state_e;

    localparam logic [1:0] VCC_OFF = 2'b00;
    localparam logic [1:0] VCC_5V  = 2'b01;
    localparam logic [1:0] VPP_OFF = 2'b00;

    // phase lengths in microseconds
    localparam longint unsigned OFF_US  = 64'd20_000 + 64'd300_000 + 64'd100_000;
    localparam longint unsigned VCC_US  = 64'd100_000 + 64'd20_000 + 64'd300_000;
    localparam longint unsigned RST_US  = 64'd10;
    localparam longint unsigned POST_US = 64'd20_000;
    localparam longint unsigned DOWN_US = 64'd20_000 + 64'd300_000;

    function automatic longint unsigned us_to_cyc(input longint unsigned hz,
                                                  input longint unsigned div,
                                                  input longint unsigned us);
        longint unsigned c;
        c = (hz * us) / 64'd1_000_000 / div;
        if (c == 64'd0) c = 64'd1;
        return c;
    endfunction

endpackage

// File: rtl/sps_timer.sv
module sps_timer #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          expired
);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (load)
            cnt <= load_val;
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign expired = (cnt == '0);

    // R10: loaded value is taken, then counts down one per cycle
    a_r10_load_taken: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> cnt == $past(load_val));
    a_r10_count_down: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && cnt != '0) |=> cnt == $past(cnt) - 1'b1);

endmodule

// File: rtl/sps_fall_det.sv
module sps_fall_det #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic fall
);

    logic [STAGES-1:0] sync_q;
    logic              prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '0;
            prev_q <= 1'b0;
        end else begin
            sync_q[0] <= din;
            for (int i = 1; i < STAGES; i++)
                sync_q[i] <= sync_q[i-1];
            prev_q <= sync_q[STAGES-1];
        end
    end

    assign fall = prev_q & ~sync_q[STAGES-1];

    // R7: a removal event is a single-cycle pulse
    a_r7_fall_single: assert property (@(posedge clk) disable iff (!rst_n)
        fall |=> !fall);

endmodule

// File: rtl/sps_fsm.sv
module sps_fsm
    import sps_pkg::*;
#(
    parameter longint unsigned OFF_CYC  = 2,
    parameter longint unsigned VCC_CYC  = 2,
    parameter longint unsigned RST_CYC  = 1,
    parameter longint unsigned POST_CYC = 2,
    parameter longint unsigned DOWN_CYC = 2,
    parameter int              CW       = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en_req,
    input  logic          dis_req,
    input  logic          removed,
    input  logic          expired,
    output logic          load,
    output logic [CW-1:0] load_val,
    output logic [1:0]    vcc_sel,
    output logic [1:0]    vpp_sel,
    output logic          card_rst,
    output logic          busy,
    output logic          ready
);

    localparam logic [CW-1:0] OFF_LD  = CW'(OFF_CYC - 1);
    localparam logic [CW-1:0] VCC_LD  = CW'(VCC_CYC - 1);
    localparam logic [CW-1:0] RST_LD  = CW'(RST_CYC - 1);
    localparam logic [CW-1:0] POST_LD = CW'(POST_CYC - 1);
    localparam logic [CW-1:0] DOWN_LD = CW'(DOWN_CYC - 1);

    seq_state_e state, nxt;
    logic       stop;

    assign stop = dis_req | removed;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:       if (en_req && !dis_req) nxt = ST_OFF_WAIT;
            ST_OFF_WAIT:   if (stop) nxt = ST_DOWN_WAIT; else if (expired) nxt = ST_VCC_WAIT;
            ST_VCC_WAIT:   if (stop) nxt = ST_DOWN_WAIT; else if (expired) nxt = ST_RESET_HOLD;
            ST_RESET_HOLD: if (stop) nxt = ST_DOWN_WAIT; else if (expired) nxt = ST_POST_RESET;
            ST_POST_RESET: if (stop) nxt = ST_DOWN_WAIT; else if (expired) nxt = ST_READY;
            ST_READY:      if (stop) nxt = ST_DOWN_WAIT;
            ST_DOWN_WAIT:  if (expired) nxt = ST_IDLE;
            default:       nxt = ST_IDLE;
        endcase
    end

    // timer load on entry to a timed state
    always_comb begin
        load     = (nxt != state) && (nxt != ST_IDLE) && (nxt != ST_READY);
        load_val = '0;
        unique case (nxt)
            ST_OFF_WAIT:   load_val = OFF_LD;
            ST_VCC_WAIT:   load_val = VCC_LD;
            ST_RESET_HOLD: load_val = RST_LD;
            ST_POST_RESET: load_val = POST_LD;
            ST_DOWN_WAIT:  load_val = DOWN_LD;
            default:       load_val = '0;
        endcase
    end

    always_comb begin
        vcc_sel  = VCC_OFF;
        vpp_sel  = VPP_OFF;
        card_rst = 1'b0;
        busy     = 1'b1;
        ready    = 1'b0;
        unique case (state)
            ST_IDLE:       busy = 1'b0;
            ST_OFF_WAIT:   ;
            ST_VCC_WAIT:   vcc_sel = VCC_5V;
            ST_RESET_HOLD: begin vcc_sel = VCC_5V; card_rst = 1'b1; end
            ST_POST_RESET: vcc_sel = VCC_5V;
            ST_READY:      begin vcc_sel = VCC_5V; busy = 1'b0; ready = 1'b1; end
            ST_DOWN_WAIT:  ;
            default:       busy = 1'b0;
        endcase
    end

    a_r2_enable_starts: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && en_req && !dis_req) |=> state == ST_OFF_WAIT);
    a_r4_reset_after_vcc: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(card_rst) |-> $past(state) == ST_VCC_WAIT);
    a_r5_ready_entry: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_READY) |-> ($past(state) == ST_READY || $past(state) == ST_POST_RESET));
    a_r6_stop_powers_down: assert property (@(posedge clk) disable iff (!rst_n)
        (stop && state != ST_IDLE && state != ST_DOWN_WAIT) |=> (state == ST_DOWN_WAIT && vcc_sel == VCC_OFF));
    a_r8_enable_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE && en_req) |=> (state != ST_OFF_WAIT || $past(state) == ST_OFF_WAIT));
    a_r9_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && dis_req) |=> state == ST_IDLE);

endmodule

// File: rtl/socket_pwr_seq.sv
module socket_pwr_seq
    import sps_pkg::*;
#(
    parameter longint unsigned CLK_HZ      = 250_000_000,
    parameter longint unsigned TICK_DIV    = 1,
    parameter int              SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en_req,
    input  logic       dis_req,
    input  logic       card_det,
    output logic [1:0] vcc_sel,
    output logic [1:0] vpp_sel,
    output logic       card_rst,
    output logic       busy,
    output logic       ready
);

    localparam longint unsigned OFF_CYC  = us_to_cyc(CLK_HZ, TICK_DIV, OFF_US);
    localparam longint unsigned VCC_CYC  = us_to_cyc(CLK_HZ, TICK_DIV, VCC_US);
    localparam longint unsigned RST_CYC  = us_to_cyc(CLK_HZ, TICK_DIV, RST_US);
    localparam longint unsigned POST_CYC = us_to_cyc(CLK_HZ, TICK_DIV, POST_US);
    localparam longint unsigned DOWN_CYC = us_to_cyc(CLK_HZ, TICK_DIV, DOWN_US);
    localparam longint unsigned MAX_A    = (OFF_CYC > VCC_CYC) ? OFF_CYC : VCC_CYC;
    localparam longint unsigned MAX_B    = (MAX_A > DOWN_CYC) ? MAX_A : DOWN_CYC;
    localparam longint unsigned MAX_CYC  = (MAX_B > POST_CYC) ? MAX_B : POST_CYC;
    localparam int              CW       = $clog2(MAX_CYC + 1);

    logic          removed;
    logic          expired;
    logic          load;
    logic [CW-1:0] load_val;

    sps_fall_det #(.STAGES(SYNC_STAGES)) u_det (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (card_det),
        .fall  (removed)
    );

    sps_timer #(.CW(CW)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .load_val (load_val),
        .expired  (expired)
    );

    sps_fsm #(
        .OFF_CYC  (OFF_CYC),
        .VCC_CYC  (VCC_CYC),
        .RST_CYC  (RST_CYC),
        .POST_CYC (POST_CYC),
        .DOWN_CYC (DOWN_CYC),
        .CW       (CW)
    ) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .en_req   (en_req),
        .dis_req  (dis_req),
        .removed  (removed),
        .expired  (expired),
        .load     (load),
        .load_val (load_val),
        .vcc_sel  (vcc_sel),
        .vpp_sel  (vpp_sel),
        .card_rst (card_rst),
        .busy     (busy),
        .ready    (ready)
    );

endmodule

// File: tb/socket_pwr_seq_tb.sv
`timescale 1ns/1ps
module socket_pwr_seq_tb;

    localparam longint unsigned HZ  = 1_000_000;
    localparam longint unsigned DIV = 200;
    localparam int OFF_C  = int'((420_000 * HZ / 1_000_000) / DIV);
    localparam int VCC_C  = int'((420_000 * HZ / 1_000_000) / DIV);
    localparam int RST_RAW = int'((10 * HZ / 1_000_000) / DIV);
    localparam int RST_C  = (RST_RAW < 1) ? 1 : RST_RAW;
    localparam int POST_C = int'((20_000 * HZ / 1_000_000) / DIV);
    localparam int DOWN_C = int'((320_000 * HZ / 1_000_000) / DIV);
    localparam int READY_IDX = OFF_C + VCC_C + RST_C + POST_C + 1;

    typedef struct packed {
        logic [15:0] idx;
        logic [3:0]  req;
        logic [1:0]  vcc;
        logic        rst;
        logic        busy;
        logic        rdy;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VEC [NV] = '{
        '{16'(1),                          4'd2, 2'b00, 1'b0, 1'b1, 1'b0},
        '{16'(OFF_C),                      4'd2, 2'b00, 1'b0, 1'b1, 1'b0},
        '{16'(OFF_C + 1),                  4'd3, 2'b01, 1'b0, 1'b1, 1'b0},
        '{16'(OFF_C + VCC_C),              4'd3, 2'b01, 1'b0, 1'b1, 1'b0},
        '{16'(OFF_C + VCC_C + 1),          4'd4, 2'b01, 1'b1, 1'b1, 1'b0},
        '{16'(OFF_C + VCC_C + RST_C + 1),  4'd5, 2'b01, 1'b0, 1'b1, 1'b0},
        '{16'(READY_IDX - 1),              4'd5, 2'b01, 1'b0, 1'b1, 1'b0},
        '{16'(READY_IDX),                  4'd5, 2'b01, 1'b0, 1'b0, 1'b1}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic en_req = 1'b0;
    logic dis_req = 1'b0;
    logic card_det = 1'b1;
    logic [1:0] vcc_sel, vpp_sel;
    logic card_rst, busy, ready;
    int vectors = 0;
    int fails = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    socket_pwr_seq #(.CLK_HZ(HZ), .TICK_DIV(DIV), .SYNC_STAGES(2)) u_dut (
        .clk(clk), .rst_n(rst_n), .en_req(en_req), .dis_req(dis_req),
        .card_det(card_det), .vcc_sel(vcc_sel), .vpp_sel(vpp_sel),
        .card_rst(card_rst), .busy(busy), .ready(ready)
    );

    function automatic string tag_of(input logic [3:0] r);
        case (r)
            4'd2:    return "R2 R10";
            4'd3:    return "R3 R10";
            4'd4:    return "R4 R10";
            default: return "R5 R10";
        endcase
    endfunction

    task automatic step(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    task automatic check(input string tag, input logic [1:0] ev, input logic er,
                         input logic eb, input logic erdy);
        logic [6:0] got, exp;
        got = {vcc_sel, vpp_sel, card_rst, busy, ready};
        exp = {ev, 2'b00, er, eb, erdy};
        vectors++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got vcc=%b vpp=%b rst=%b busy=%b ready=%b, expected vcc=%b vpp=00 rst=%b busy=%b ready=%b",
                     tag, vcc_sel, vpp_sel, card_rst, busy, ready, ev, er, eb, erdy);
        end
    endtask

    // drive enable for one cycle; returns at sample index 1
    task automatic pulse_en();
        en_req = 1'b1;
        step(1);
        en_req = 1'b0;
    endtask

    task automatic pulse_dis();
        dis_req = 1'b1;
        step(1);
        dis_req = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (190_000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: run did not complete");
        finish_run();
    end

    initial begin
        int cur;
        @(negedge clk);
        check("R1 in reset", 2'b00, 1'b0, 1'b0, 1'b0);
        step(3);
        rst_n = 1'b1;
        step(2);
        check("R1 after reset", 2'b00, 1'b0, 1'b0, 1'b0);

        // table walk through a full power-up
        pulse_en();
        cur = 1;
        for (int v = 0; v < NV; v++) begin
            if (int'(VEC[v].idx) > cur) step(int'(VEC[v].idx) - cur);
            cur = int'(VEC[v].idx);
            check(tag_of(VEC[v].req), VEC[v].vcc, VEC[v].rst, VEC[v].busy, VEC[v].rdy);
        end

        // R8: enable in READY ignored
        pulse_en();
        check("R8 enable in ready", 2'b01, 1'b0, 1'b0, 1'b1);
        step(5);
        check("R8 still ready", 2'b01, 1'b0, 1'b0, 1'b1);

        // R6: disable from READY, full down wait
        pulse_dis();
        check("R6 down entry", 2'b00, 1'b0, 1'b1, 1'b0);
        step(DOWN_C - 1);
        check("R6 down last cycle", 2'b00, 1'b0, 1'b1, 1'b0);
        step(1);
        check("R6 back to idle", 2'b00, 1'b0, 1'b0, 1'b0);

        // R9: disable in idle, and disable beating enable
        pulse_dis();
        step(2);
        check("R9 disable in idle", 2'b00, 1'b0, 1'b0, 1'b0);
        en_req = 1'b1;
        dis_req = 1'b1;
        step(1);
        en_req = 1'b0;
        dis_req = 1'b0;
        step(2);
        check("R9 disable wins over enable", 2'b00, 1'b0, 1'b0, 1'b0);

        // R8: enable during OFF_WAIT does not restart the timer
        pulse_en();
        step(4);
        pulse_en();
        step(OFF_C - 6);
        check("R8 off wait end unchanged", 2'b00, 1'b0, 1'b1, 1'b0);
        step(1);
        check("R8 vcc on at original time", 2'b01, 1'b0, 1'b1, 1'b0);
        // R6: disable during VCC_WAIT
        step(50);
        pulse_dis();
        check("R6 disable in vcc wait", 2'b00, 1'b0, 1'b1, 1'b0);
        step(DOWN_C);
        check("R6 idle after abort", 2'b00, 1'b0, 1'b0, 1'b0);

        // R7: card removal while READY
        pulse_en();
        step(READY_IDX - 1);
        check("R7 ready before removal", 2'b01, 1'b0, 1'b0, 1'b1);
        card_det = 1'b0;
        step(2);
        check("R7 still ready during sync", 2'b01, 1'b0, 1'b0, 1'b1);
        step(1);
        check("R7 removal powers down", 2'b00, 1'b0, 1'b1, 1'b0);
        step(DOWN_C);
        check("R7 idle after removal", 2'b00, 1'b0, 1'b0, 1'b0);
        card_det = 1'b1;
        step(4);

        // R7: removal during POST_RESET
        pulse_en();
        step(OFF_C + VCC_C + RST_C + 3 - 1);
        check("R7 in post reset", 2'b01, 1'b0, 1'b1, 1'b0);
        card_det = 1'b0;
        step(3);
        check("R7 removal aborts post reset", 2'b00, 1'b0, 1'b1, 1'b0);
        step(DOWN_C);
        check("R7 idle after abort", 2'b00, 1'b0, 1'b0, 1'b0);
        card_det = 1'b1;
        step(4);

        // R9: removal in idle ignored
        card_det = 1'b0;
        step(5);
        check("R9 removal in idle", 2'b00, 1'b0, 1'b0, 1'b0);

        finish_run();
    end

endmodule